// File: doc/BRIEF.md
# Sequence Lock with Alarm

This block is a Mealy state machine that watches two one-cycle symbol inputs, A and B, and unlocks when the stored six-symbol combination A, A, B, A, B, A has been keyed in. The unlock pulse and the alarm pulse are combinational in the present input and the registered state, so they appear in the same cycle as the symbol that triggers them. An A that arrives where the combination expects a B rings the alarm and restarts the search. A run of three B symbols returns the lock to its start state from anywhere. Once the lock has opened, the next valid symbol closes it again.

The design is split into four parts. A symbol decoder classifies each cycle as idle, A, B or a conflict. A progress tracker holds the number of combination symbols matched so far. A run counter counts consecutive B symbols and emits a flush when the run reaches its limit. A two-state mode machine, with the states TRACKING and OPENED, joins these parts. Its transitions are as follows. TRACKING goes to OPENED when the final symbol of the combination matches. TRACKING stays in TRACKING on any other input. OPENED goes to TRACKING on any valid symbol. OPENED stays in OPENED on an idle or conflicting cycle.

The combination, its length and the run limit are elaboration parameters. They cannot be changed at run time.

Top module: `seq_lock_top`

## Requirements
- R1: After reset, `unlock` and `alarm` are low, and the lock is at the start of the combination with a B-run count of zero.
- R2: `unlock` is high in exactly the cycle in which the final A of A, A, B, A, B, A is presented, and the lock then enters the opened state.
- R3: An A presented where the combination expects a B raises `alarm` in that same cycle and resets progress to the start. That A does not count as the first symbol of a new attempt.
- R4: A B presented where the combination expects an A raises no alarm, resets progress to the start, and adds one to the consecutive-B count.
- R5: Three consecutive B symbols, counted across idle cycles, return the lock to its start state and clear the count, whatever the progress was. Any A clears the count.
- R6: In the opened state, the next A or B returns the lock to its start state. That symbol raises neither output and is not counted toward the combination.
- R7: A cycle with neither `sym_a` nor `sym_b` high changes no state and raises neither output.
- R8: A cycle with both `sym_a` and `sym_b` high is ignored: no state changes and neither output is raised.
- R9: `unlock` and `alarm` are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_a | input | 1 | One-cycle pulse: symbol A entered |
| sym_b | input | 1 | One-cycle pulse: symbol B entered |
| unlock | output | 1 | Mealy pulse: combination completed |
| alarm | output | 1 | Mealy pulse: out-of-sequence A |

## Verification
The bench builds the lock with its default parameters: the six-symbol combination with one bit per symbol, where a set bit means B, and a run limit of three.

The first sweep presents every six-cycle stream over all four input codes (idle, A, B, both) after reset. This covers every placement of idle and conflicting cycles against each level of progress and each B-run count.

The second sweep presents every twelve-symbol stream of A and B. This reaches a full opening followed by the closing symbol, a second attempt that follows, and every place where a three-B flush can cut into partial progress.

A reference model written arithmetically in the bench predicts both outputs in every cycle.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;

    typedef enum logic [1:0] {
        SYM_IDLE = 2'b00,
        SYM_A    = 2'b01,
        SYM_B    = 2'b10,
        SYM_BOTH = 2'b11
    } sym_t;

    typedef enum logic {
        ST_TRACKING = 1'b0,
        ST_OPENED   = 1'b1
    } lock_mode_t;

endpackage

// File: rtl/seq_lock_decode.sv
module seq_lock_decode
    import seq_lock_pkg::*;
(
    input  logic sym_a,
    input  logic sym_b,
    output sym_t sym,
    output logic valid,
    output logic is_a,
    output logic is_b
);

    always_comb begin
        unique case ({sym_b, sym_a})
            2'b00:   sym = SYM_IDLE;
            2'b01:   sym = SYM_A;
            2'b10:   sym = SYM_B;
            default: sym = SYM_BOTH;
        endcase
    end

    assign is_a  = (sym == SYM_A);
    assign is_b  = (sym == SYM_B);
    assign valid = is_a | is_b;

endmodule

// File: rtl/seq_lock_tracker.sv
module seq_lock_tracker #(
    parameter int              SEQ_LEN = 6,
    parameter logic [SEQ_LEN-1:0] SEQ_CODE = 6'b010100,
    localparam int             PW      = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          step_is_b,
    input  logic          clear,
    output logic          hit,
    output logic          complete,
    output logic          miss_a,
    output logic [PW-1:0] progress
);

    logic          expect_b;
    logic          at_last;
    logic [PW-1:0] progress_nxt;

    assign expect_b = SEQ_CODE[progress];
    assign at_last  = (progress == PW'(SEQ_LEN - 1));
    assign hit      = step && (step_is_b == expect_b);
    assign complete = hit && at_last;
    assign miss_a   = step && !step_is_b && expect_b;

    always_comb begin
        progress_nxt = progress;
        if (clear) begin
            progress_nxt = '0;
        end else if (step) begin
            if (hit && !at_last) begin
                progress_nxt = progress + PW'(1);
            end else begin
                progress_nxt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            progress <= '0;
        end else begin
            progress <= progress_nxt;
        end
    end

    // R3: an out-of-order A restarts the search
    a_r3_miss_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        miss_a |=> (progress == '0));

    // R4: a B where an A is expected restarts the search
    a_r4_b_miss_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (step && step_is_b && !expect_b) |=> (progress == '0));

    // R2: the final match always leaves the tracker at the start
    a_r2_complete_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> (progress == '0));

endmodule

// File: rtl/seq_lock_brun.sv
module seq_lock_brun #(
    parameter int  RUN_LIMIT = 3,
    localparam int CW        = (RUN_LIMIT > 1) ? $clog2(RUN_LIMIT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          got_a,
    input  logic          got_b,
    input  logic          clear,
    output logic          flush,
    output logic [CW-1:0] run_cnt
);

    logic          at_limit;
    logic [CW-1:0] run_nxt;

    assign at_limit = (run_cnt == CW'(RUN_LIMIT - 1));
    assign flush    = got_b && at_limit;

    always_comb begin
        run_nxt = run_cnt;
        if (clear || got_a || flush) begin
            run_nxt = '0;
        end else if (got_b) begin
            run_nxt = run_cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_nxt;
        end
    end

    // R5: a completed B run empties the counter
    a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (run_cnt == '0));

    // R5: any A empties the counter
    a_r5_a_empties: assert property (@(posedge clk) disable iff (!rst_n)
        got_a |=> (run_cnt == '0));

    // R5: a B below the limit extends the run by one
    a_r5_b_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (got_b && !at_limit && !clear) |=> (run_cnt == $past(run_cnt) + CW'(1)));

endmodule

// File: rtl/seq_lock_top.sv
module seq_lock_top
    import seq_lock_pkg::*;
#(
    parameter int                 SEQ_LEN   = 6,
    parameter logic [SEQ_LEN-1:0] SEQ_CODE  = 6'b010100,
    parameter int                 RUN_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_a,
    input  logic sym_b,
    output logic unlock,
    output logic alarm
);

    localparam int PW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
    localparam int CW = (RUN_LIMIT > 1) ? $clog2(RUN_LIMIT) : 1;

    sym_t          sym;
    logic          valid;
    logic          is_a;
    logic          is_b;
    lock_mode_t    mode;
    lock_mode_t    mode_nxt;
    logic          tracking;
    logic          step;
    logic          prog_clear;
    logic          run_clear;
    logic          hit;
    logic          complete;
    logic          miss_a;
    logic          flush;
    logic [PW-1:0] progress;
    logic [CW-1:0] run_cnt;

    seq_lock_decode u_decode (
        .sym_a (sym_a),
        .sym_b (sym_b),
        .sym   (sym),
        .valid (valid),
        .is_a  (is_a),
        .is_b  (is_b)
    );

    assign tracking   = (mode == ST_TRACKING);
    assign step       = tracking && valid;
    assign run_clear  = !tracking && valid;
    assign prog_clear = run_clear || (tracking && flush);

    seq_lock_tracker #(
        .SEQ_LEN  (SEQ_LEN),
        .SEQ_CODE (SEQ_CODE)
    ) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .step_is_b (is_b),
        .clear     (prog_clear),
        .hit       (hit),
        .complete  (complete),
        .miss_a    (miss_a),
        .progress  (progress)
    );

    seq_lock_brun #(
        .RUN_LIMIT (RUN_LIMIT)
    ) u_brun (
        .clk     (clk),
        .rst_n   (rst_n),
        .got_a   (is_a),
        .got_b   (is_b),
        .clear   (run_clear),
        .flush   (flush),
        .run_cnt (run_cnt)
    );

    // next-state logic and state register
    always_comb begin
        mode_nxt = mode;
        unique case (mode)
            ST_TRACKING: if (complete && !flush) mode_nxt = ST_OPENED;
            ST_OPENED:   if (valid)              mode_nxt = ST_TRACKING;
            default:                             mode_nxt = ST_TRACKING;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= ST_TRACKING;
        end else begin
            mode <= mode_nxt;
        end
    end

    // Mealy outputs
    always_comb begin
        unlock = 1'b0;
        alarm  = 1'b0;
        unique case (mode)
            ST_TRACKING: begin
                unlock = complete && !flush;
                alarm  = miss_a;
            end
            ST_OPENED: begin
                unlock = 1'b0;
                alarm  = 1'b0;
            end
            default: begin
                unlock = 1'b0;
                alarm  = 1'b0;
            end
        endcase
    end

    // R9: the two pulses never coincide
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(unlock && alarm));

    // R2: an unlock pulse moves the lock into the opened state
    a_r2_unlock_opens: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |=> (mode == ST_OPENED));

    // R6: a valid symbol in the opened state closes the lock and resets progress
    a_r6_open_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (!tracking && valid) |=> (tracking && progress == '0 && run_cnt == '0));

    // R7: idle cycles hold every state element
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sym == SYM_IDLE) |=> ($stable(mode) && $stable(progress) && $stable(run_cnt)));

    // R8: conflicting cycles hold every state element
    a_r8_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sym == SYM_BOTH) |=> ($stable(mode) && $stable(progress) && $stable(run_cnt)));

    // R6: the opened state raises neither output
    a_r6_quiet_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        !tracking |-> (!unlock && !alarm));

endmodule

// File: tb/sim_seq_lock_top.sv
module sim_seq_lock_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_a = 1'b0;
    logic sym_b = 1'b0;
    logic unlock;
    logic alarm;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    // reference model state
    int  m_prog;
    int  m_run;
    bit  m_open;
    int  want_b [6] = '{0, 0, 1, 0, 1, 0};

    seq_lock_top u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .sym_a  (sym_a),
        .sym_b  (sym_b),
        .unlock (unlock),
        .alarm  (alarm)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            n_fails++;
            $display("FAIL R1 watchdog: ran %0d cycles, expected fewer than %0d", cycles, WATCHDOG);
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sym_a = 1'b0;
        sym_b = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n  = 1'b1;
        m_prog = 0;
        m_run  = 0;
        m_open = 1'b0;
    endtask

    // code: 0 idle, 1 A, 2 B, 3 both
    task automatic apply(input int code);
        bit    a;
        bit    b;
        bit    e_u;
        bit    e_al;
        string tag;
        a = code[0];
        b = code[1];
        @(negedge clk);
        sym_a = a;
        sym_b = b;
        e_u  = 1'b0;
        e_al = 1'b0;
        if (m_open && (a ^ b))      tag = "R6";
        else if (a && b)            tag = "R8";
        else if (!a && !b)          tag = "R7";
        else if (b && m_run == 2)   tag = "R5";
        else if (b)                 tag = "R4";
        else if (want_b[m_prog] == 1) tag = "R3";
        else                        tag = "R2";
        if (a ^ b) begin
            if (m_open) begin
                m_open = 1'b0;
                m_prog = 0;
                m_run  = 0;
            end else if (a) begin
                m_run = 0;
                if (want_b[m_prog] == 0) begin
                    if (m_prog == 5) begin
                        e_u    = 1'b1;
                        m_open = 1'b1;
                        m_prog = 0;
                    end else begin
                        m_prog = m_prog + 1;
                    end
                end else begin
                    e_al   = 1'b1;
                    m_prog = 0;
                end
            end else begin
                if (m_run == 2) begin
                    m_run  = 0;
                    m_prog = 0;
                end else begin
                    m_run = m_run + 1;
                    if (want_b[m_prog] == 1) m_prog = m_prog + 1;
                    else                     m_prog = 0;
                end
            end
        end
        #2;
        check(tag, unlock, e_u, "unlock");
        check(tag, alarm, e_al, "alarm");
        check("R9", unlock & alarm, 1'b0, "unlock and alarm together");
    endtask

    initial begin
        // R1: outputs low in and just after reset
        @(negedge clk);
        #2;
        check("R1", unlock, 1'b0, "unlock during reset");
        check("R1", alarm, 1'b0, "alarm during reset");
        do_reset();
        #2;
        check("R1", unlock, 1'b0, "unlock after reset");
        check("R1", alarm, 1'b0, "alarm after reset");

        // R2: the combination straight after reset opens the lock
        apply(1); apply(1); apply(2); apply(1); apply(2); apply(1);
        // R6: the next symbol closes it quietly, then the combination works again
        apply(2);
        apply(1); apply(1); apply(2); apply(1); apply(2); apply(1);

        // R5: A A B B B flushes, then a fresh combination opens
        do_reset();
        apply(1); apply(1); apply(2); apply(2); apply(2);
        apply(1); apply(1); apply(2); apply(1); apply(2); apply(1);

        // R3: A A A rings the alarm, the ringing A does not start a new attempt
        do_reset();
        apply(1); apply(1); apply(1);
        apply(1); apply(2); apply(1); apply(2); apply(1);

        // R7 and R8: idle and conflicting cycles inside a combination
        do_reset();
        apply(1); apply(0); apply(3); apply(1); apply(0); apply(2);
        apply(3); apply(1); apply(0); apply(2); apply(3); apply(1);

        // sweep: every six-cycle stream over the four input codes
        for (int s = 0; s < 4096; s++) begin
            do_reset();
            for (int i = 0; i < 6; i++) apply((s >> (2 * i)) & 3);
        end

        // sweep: every twelve-symbol stream of A and B
        for (int s = 0; s < 4096; s++) begin
            do_reset();
            for (int i = 0; i < 12; i++) apply(((s >> i) & 1) ? 2 : 1);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule